// File: doc/BRIEF.md
# Register-Mapped Subtractive GCD Peripheral

This block places an iterative greatest-common-divisor unit behind a small bus-slave register window. The window has separate read and write strobes, a word address and a data bus. Each register is tied to one side of a ready/valid handshake toward the engine. Writing the second operand launches a run. Reading the result acknowledges it and releases the engine.

Software first stores operand A in a plain register. It then writes operand B to the trigger register, and that write starts the engine. It polls the status register until a result is flagged, and then reads the result register once. The engine finds the answer by repeated subtraction. It takes one subtraction step per clock, so the run length depends on the operand values. The data width is fixed at elaboration.

Top module: `gcd_mmio_regs`

## Requirements
- R1: After reset, the read data bus is zero and the status register reads 1, which means the engine is idle and no result is waiting.
- R2: Writing operand A at offset 0x04 only stores the value. The status register still reads 1 afterwards.
- R3: A write to offset 0x08 while the engine is idle starts a run with the stored operand A and the written value as operand B. While the run is in progress, status reads 0.
- R4: When both operands are non-zero, the result is their greatest common divisor. It is found by subtracting the smaller value from the larger until the two are equal.
- R5: If either operand is zero, the result is the other operand. If both are zero, the result is zero.
- R6: Status is at offset 0x00. Bit 0 set means the engine can accept new operands. Bit 1 set means a result is waiting. All other status bits read zero.
- R7: A read of offset 0x0C while a result is waiting returns the result and consumes it. After that read, status reads 1 and a second read of 0x0C returns zero.
- R8: A write to 0x08 while a run is in progress, or while a result is waiting, is ignored. The result returned is the one for the original operands.
- R9: A read of 0x0C when no result is waiting returns zero and changes nothing; status is unchanged.
- R10: Reads of the write-only offsets 0x04 and 0x08, and reads of any unmapped offset, return zero. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
The hardest case to reach from the ports is a trigger write that arrives while the engine is busy, or while a finished result has not yet been read. Both windows last only as long as the run does. To hit them, the stimulus picks operand pairs whose subtraction chains take several cycles, and it issues the second trigger in the cycles right after the first. It issues one more trigger after the run has finished but before the result is read. A behavioural model of the engine, running on every clock, confirms that those trigger writes changed nothing. The model also checks that the result read afterwards still matches the first operand pair.

// File: rtl/gcd_mmio_pkg.sv
`timescale 1ns/1ps
package gcd_mmio_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_HOLD = 2'd2
  } eng_state_t;

  localparam int OFS_STATUS = 'h0;
  localparam int OFS_OPA    = 'h4;
  localparam int OFS_OPB    = 'h8;
  localparam int OFS_RESULT = 'hC;

  localparam int STATUS_BITS = 2;

endpackage

// File: rtl/gcd_sub_engine.sv
`timescale 1ns/1ps
module gcd_sub_engine
  import gcd_mmio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result
);

  localparam logic [DATA_W-1:0] ZERO = '0;

  eng_state_t        state;
  logic [DATA_W-1:0] x_q, y_q, res_q;
  logic              x_zero, y_zero, same, x_big;

  assign x_zero = (x_q == ZERO);
  assign y_zero = (y_q == ZERO);
  assign same   = (x_q == y_q);
  assign x_big  = (x_q > y_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ENG_IDLE;
      x_q   <= ZERO;
      y_q   <= ZERO;
      res_q <= ZERO;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (in_valid) begin
            x_q   <= in_a;
            y_q   <= in_b;
            state <= ENG_RUN;
          end
        end
        ENG_RUN: begin
          if (x_zero) begin
            res_q <= y_q;
            state <= ENG_HOLD;
          end else if (y_zero || same) begin
            res_q <= x_q;
            state <= ENG_HOLD;
          end else if (x_big) begin
            x_q <= x_q - y_q;
          end else begin
            y_q <= y_q - x_q;
          end
        end
        ENG_HOLD: begin
          if (out_ready) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign in_ready   = (state == ENG_IDLE);
  assign out_valid  = (state == ENG_HOLD);
  assign out_result = res_q;

  // R3
  start_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

  // R5
  zero_left_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_RUN && x_zero) |=> (out_valid && out_result == $past(y_q)));

  // R7
  consume_release_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> in_ready);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && !out_ready) |=> !in_ready);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

endmodule

// File: rtl/gcd_reg_decode.sv
`timescale 1ns/1ps
module gcd_reg_decode
  import gcd_mmio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              eng_in_valid,
  output logic [DATA_W-1:0] eng_in_a,
  output logic [DATA_W-1:0] eng_in_b,
  input  logic              eng_in_ready,
  input  logic              eng_out_valid,
  output logic              eng_out_ready,
  input  logic [DATA_W-1:0] eng_result
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_OPA    = ADDR_W'(OFS_OPA);
  localparam logic [ADDR_W-1:0] A_OPB    = ADDR_W'(OFS_OPB);
  localparam logic [ADDR_W-1:0] A_RESULT = ADDR_W'(OFS_RESULT);
  localparam int               PAD_W    = DATA_W - STATUS_BITS;

  logic [DATA_W-1:0] opa_q;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] read_mux;

  assign status_word = {{PAD_W{1'b0}}, eng_out_valid, eng_in_ready};

  always_ff @(posedge clk) begin
    if (rst) opa_q <= '0;
    else if (wr_en && addr == A_OPA) opa_q <= wdata;
  end

  assign eng_in_valid  = wr_en && (addr == A_OPB);
  assign eng_in_a      = opa_q;
  assign eng_in_b      = wdata;
  assign eng_out_ready = rd_en && (addr == A_RESULT) && eng_out_valid;

  always_comb begin
    read_mux = '0;
    if (addr == A_STATUS) read_mux = status_word;
    else if (addr == A_RESULT && eng_out_valid) read_mux = eng_result;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= read_mux;
  end

  // R9
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_RESULT && !eng_out_valid) |=> (rdata == '0));

  // R10
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == A_OPA || addr == A_OPB)) |=> (rdata == '0));

  // R6
  status_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_STATUS) |=> ($countones(rdata) <= 1 && rdata[DATA_W-1:STATUS_BITS] == '0));

endmodule

// File: rtl/gcd_mmio_regs.sv
`timescale 1ns/1ps
module gcd_mmio_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic              in_valid, in_ready, out_valid, out_ready;
  logic [DATA_W-1:0] in_a, in_b, result;

  gcd_reg_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .eng_in_valid(in_valid), .eng_in_a(in_a), .eng_in_b(in_b),
    .eng_in_ready(in_ready), .eng_out_valid(out_valid),
    .eng_out_ready(out_ready), .eng_result(result)
  );

  gcd_sub_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(result)
  );

endmodule

// File: tb/gcd_mmio_regs_test.sv
`timescale 1ns/1ps
module gcd_mmio_regs_test;

  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gcd_mmio_regs #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // behavioural reference: 0 idle, 1 running, 2 result waiting
  int          m_st = 0;
  int unsigned m_x = 0, m_y = 0, m_res = 0, m_opa = 0, m_rd = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_x = 0; m_y = 0; m_res = 0; m_opa = 0; m_rd = 0;
    end else begin
      int unsigned a_i;
      a_i = int'(addr);
      if (rd_en) begin
        if (a_i == 0) m_rd = ((m_st == 2) ? 2 : 0) + ((m_st == 0) ? 1 : 0);
        else if (a_i == 12 && m_st == 2) m_rd = m_res;
        else m_rd = 0;
      end
      case (m_st)
        0: if (wr_en && a_i == 8) begin m_x = m_opa; m_y = wdata; m_st = 1; end
        1: begin
          if (m_x == 0) begin m_res = m_y; m_st = 2; end
          else if (m_y == 0 || m_x == m_y) begin m_res = m_x; m_st = 2; end
          else if (m_x > m_y) m_x = m_x - m_y;
          else m_y = m_y - m_x;
        end
        default: if (rd_en && a_i == 12) m_st = 0;
      endcase
      if (wr_en && a_i == 4) m_opa = wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      n_cmp++;
      if (rdata !== DW'(m_rd)) begin
        n_bad++;
        $display("FAIL R4 model compare: rdata got %0d expected %0d at %0t", rdata, m_rd, $time);
      end
    end
  end

  function automatic int unsigned euclid(int unsigned a, int unsigned b);
    int unsigned t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input int unsigned got, input int unsigned exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input int unsigned d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output int unsigned v);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic wait_result(input string req);
    int unsigned s;
    for (int i = 0; i < 3000; i++) begin
      rd(0, s);
      if (s == 2) return;
    end
    chk(1'b0, req, s, 2);
  endtask

  task automatic run_pair(input int unsigned a, input int unsigned b, input string req);
    int unsigned v, exp;
    exp = euclid(a, b);
    wr(4, a);
    wr(8, b);
    wait_result(req);
    rd(12, v);
    chk(v == exp, req, v, exp);
    rd(0, v);
    chk(v == 1, "R7 status after consume", v, 1);
    rd(12, v);
    chk(v == 0, "R7 second result read", v, 0);
  endtask

  initial begin
    int unsigned v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk(rdata == 0, "R1 rdata after reset", rdata, 0);
    rd(0, v);
    chk(v == 1, "R1 status after reset", v, 1);
    // R10
    rd(4, v);  chk(v == 0, "R10 read of operand A offset", v, 0);
    rd(8, v);  chk(v == 0, "R10 read of trigger offset", v, 0);
    rd(2, v);  chk(v == 0, "R10 unmapped offset", v, 0);
    // R9
    rd(12, v); chk(v == 0, "R9 empty result read", v, 0);
    rd(0, v);  chk(v == 1, "R9 status unchanged", v, 1);
    // R2, R3, R6
    wr(4, 48);
    rd(0, v);  chk(v == 1, "R2 operand A no side effect", v, 1);
    wr(8, 18);
    rd(0, v);  chk(v == 0, "R3 busy status", v, 0);
    wait_result("R6 result-waiting bit");
    rd(12, v); chk(v == 6, "R4 gcd 48,18", v, 6);
    // R4
    run_pair(17, 5, "R4 coprime");
    run_pair(7, 7, "R4 equal operands");
    run_pair(100, 75, "R4 gcd 100,75");
    run_pair(1, 200, "R4 long chain");
    // R5
    run_pair(0, 9, "R5 zero A");
    run_pair(12, 0, "R5 zero B");
    run_pair(0, 0, "R5 both zero");
    // R8
    wr(4, 48);
    wr(8, 18);
    wr(8, 100);
    wait_result("R8 busy trigger");
    wr(8, 5);
    rd(0, v);  chk(v == 2, "R8 status after trigger in hold", v, 2);
    rd(12, v); chk(v == 6, "R8 result kept", v, 6);
    rd(0, v);  chk(v == 1, "R7 idle after consume", v, 1);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule